// File: doc/BRIEF.md
# Aggregated Interrupt Cause Controller

This block gathers single-cycle event pulses into three 32-bit cause groups: transmit, receive and miscellaneous. Each group latches its events, keeps its own mask with separate set and clear write strobes, and has a per-bit clear-mode setting. That setting chooses whether a bit is acknowledged by reading the cause word or by writing a 1 to it. Any bit can be masked and still stays pending, so it shows up later when software unmasks it.

Each group's unmasked pending bits are ORed into a three-bit summary word. A summary bit is captured when its group goes from having nothing to report to having something to report. Reading the summary word clears it. The summary has its own mask, and the unmasked summary bits drive one registered, level-sensitive interrupt line. Software reaches everything through a word-addressed register port: it writes in one cycle, and read data appears one cycle after the read strobe.

The address is split in two parts. The upper two bits choose the page: 0 for transmit, 1 for receive, 2 for miscellaneous and 3 for the summary. The lower three bits choose the register inside that page.

Top module: `icc_ctrl`

## Requirements
- R1: An event pulse on any bit sets the matching cause bit at the next clock edge, whether or not the bit is masked. If an event and a read-clear or write-clear of the same bit fall in the same cycle, the bit stays set.
- R2: Group page offset 0 is the cause word. Offset 4 is the clear-mode word, which can be read and written. A cause bit whose mode bit is 1 is cleared by reading offset 0, and writing to it has no effect. A cause bit whose mode bit is 0 is cleared only by writing 1 to it at offset 0, and reading it does not clear it.
- R3: Writing a word to group offset 1 sets the mask bit for every 1 in that word. Mask bits for the 0s in the word are left as they were.
- R4: Writing a word to group offset 2 clears the mask bit for every 1 in that word. Mask bits for the 0s in the word are left as they were.
- R5: Group offset 3 returns the current mask and is read-only. Writing to it changes nothing.
- R6: Summary page offset 0 (address 0x18) holds one bit per group: bit 0 for transmit, bit 1 for receive, bit 2 for miscellaneous. A bit is set in the cycle after its group goes from no unmasked pending bits to at least one. The word clears when read, unless a new set arrives in the same cycle.
- R7: Summary page offset 1 (address 0x19) is the summary mask, which can be read and written; a 1 blocks that group. Summary bits still latch while blocked. Writing all ones keeps the interrupt line low.
- R8: The interrupt output is a register. At each clock edge it is loaded with whether any summary bit is set and not blocked by the summary mask. An event therefore raises the line two edges after the edge that latched it.
- R9: After reset, every cause bit, summary bit and clear-mode bit is 0, every group mask bit is 1, every summary mask bit is 1, and the interrupt output is low.
- R10: Read data is registered. It holds the addressed value in the cycle after the read strobe and is 0 at all other times. Unmapped offsets read as 0.
- R11: In the transmit group, bits 0 to 24 are per-ring completion flags and bit 31 is the overall transmit-done flag. Each one latches and clears on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_tx_i | input | 32 | Transmit event pulses (ring flags 0..24, done flag 31) |
| ev_rx_i | input | 32 | Receive event pulses |
| ev_misc_i | input | 32 | Miscellaneous event pulses |
| addr_i | input | 5 | Word address: page in bits 4:3, offset in bits 2:0 |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt level |

## Verification
Some properties are checked on every cycle. Events always land in the cause bits. A cause bit never falls unless its own cause word was accessed. Mask words change only as the set and clear writes allow, and they stay stable otherwise. Summary bits fall only on a summary read. The interrupt line follows the previous cycle's unblocked summary, and a fully blocked summary forces it low. Other behaviour can only be shown by the bench's scenarios. These are the per-bit clear-mode split, an event landing in the same cycle as a read-clear or write-clear, the edge-triggered summary being re-armed by unmasking, writes to the read-only mask view being ignored, and the values restored by a reset in the middle of a run.

// File: rtl/icc_pkg.sv
package icc_pkg;

  // group indices; summary bit positions follow them
  localparam int N_GRP    = 3;
  localparam int GRP_TX   = 0;
  localparam int GRP_RX   = 1;
  localparam int GRP_MISC = 2;

  // each page is 2**OFF_W words; the page after the last group is the summary
  localparam int OFF_W    = 3;
  localparam int GRP_SPAN = 1 << OFF_W;

  typedef enum logic [OFF_W-1:0] {
    OFF_CAUSE = 3'd0,
    OFF_MSET  = 3'd1,
    OFF_MCLR  = 3'd2,
    OFF_MVAL  = 3'd3,
    OFF_MODE  = 3'd4
  } grp_off_e;

  localparam logic [OFF_W-1:0] SUM_OFF_CAUSE = 3'd0;
  localparam logic [OFF_W-1:0] SUM_OFF_MASK  = 3'd1;

  function automatic int addr_width(input int groups);
    return $clog2((groups + 1) * GRP_SPAN);
  endfunction

endpackage

// File: rtl/icc_group.sv
module icc_group #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ev,
  input  logic         rd_cause,
  input  logic         wr_cause,
  input  logic         wr_mset,
  input  logic         wr_mclr,
  input  logic         wr_mode,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cause_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] mode_o,
  output logic         pend_o
);

  logic [W-1:0] cause_q, mask_q, mode_q;
  logic [W-1:0] rd_clr, wr_clr, set_m, clr_m;

  // read clears only clear-on-read bits, write-one clears only the others
  assign rd_clr = {W{rd_cause}} & mode_q;
  assign wr_clr = {W{wr_cause}} & wdata & ~mode_q;
  assign set_m  = {W{wr_mset}} & wdata;
  assign clr_m  = {W{wr_mclr}} & wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      mask_q  <= '1;
      mode_q  <= '0;
    end else begin
      // new events override a same-cycle clear
      cause_q <= (cause_q & ~(rd_clr | wr_clr)) | ev;
      mask_q  <= (mask_q | set_m) & ~clr_m;
      if (wr_mode) mode_q <= wdata;
    end
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;
  assign mode_o  = mode_q;
  assign pend_o  = |(cause_q & ~mask_q);

endmodule

// File: rtl/icc_summary.sv
module icc_summary #(
  parameter int G = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [G-1:0] act,
  input  logic         rd_sum,
  input  logic         wr_smask,
  input  logic [G-1:0] wdata,
  output logic [G-1:0] sum_o,
  output logic [G-1:0] smask_o,
  output logic         irq_o
);

  logic [G-1:0] act_q, sum_q, smask_q, rise;
  logic         irq_q;

  assign rise = act & ~act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= '0;
      sum_q   <= '0;
      smask_q <= '1;
      irq_q   <= 1'b0;
    end else begin
      act_q <= act;
      sum_q <= (sum_q & ~{G{rd_sum}}) | rise;
      if (wr_smask) smask_q <= wdata;
      irq_q <= |(sum_q & ~smask_q);
    end
  end

  assign sum_o   = sum_q;
  assign smask_o = smask_q;
  assign irq_o   = irq_q;

endmodule

// File: rtl/icc_regif.sv
module icc_regif import icc_pkg::*; #(
  parameter int W  = 32,
  parameter int G  = 3,
  parameter int AW = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       addr,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [G-1:0][W-1:0] cause,
  input  logic [G-1:0][W-1:0] mask,
  input  logic [G-1:0][W-1:0] mode,
  input  logic [G-1:0]        sum,
  input  logic [G-1:0]        smask,
  output logic [G-1:0]        rd_cause,
  output logic [G-1:0]        wr_cause,
  output logic [G-1:0]        wr_mset,
  output logic [G-1:0]        wr_mclr,
  output logic [G-1:0]        wr_mode,
  output logic                rd_sum,
  output logic                wr_smask,
  output logic [W-1:0]        rd_data
);

  localparam int PW = AW - OFF_W;
  localparam logic [PW-1:0] SUM_PAGE = PW'(G);

  logic [PW-1:0]    page;
  logic [OFF_W-1:0] off;
  logic [W-1:0]     rd_mux, rd_q;

  assign page = addr[AW-1:OFF_W];
  assign off  = addr[OFF_W-1:0];

  for (genvar g = 0; g < G; g++) begin : g_dec
    logic hit;
    assign hit         = (page == PW'(g));
    assign rd_cause[g] = rd_en & hit & (off == OFF_CAUSE);
    assign wr_cause[g] = wr_en & hit & (off == OFF_CAUSE);
    assign wr_mset[g]  = wr_en & hit & (off == OFF_MSET);
    assign wr_mclr[g]  = wr_en & hit & (off == OFF_MCLR);
    assign wr_mode[g]  = wr_en & hit & (off == OFF_MODE);
  end

  assign rd_sum   = rd_en & (page == SUM_PAGE) & (off == SUM_OFF_CAUSE);
  assign wr_smask = wr_en & (page == SUM_PAGE) & (off == SUM_OFF_MASK);

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < G; g++) begin
      if (page == PW'(g)) begin
        case (off)
          OFF_CAUSE: rd_mux = cause[g];
          OFF_MVAL:  rd_mux = mask[g];
          OFF_MODE:  rd_mux = mode[g];
          default:   rd_mux = '0;
        endcase
      end
    end
    if (page == SUM_PAGE) begin
      if (off == SUM_OFF_CAUSE)     rd_mux = {{(W-G){1'b0}}, sum};
      else if (off == SUM_OFF_MASK) rd_mux = {{(W-G){1'b0}}, smask};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
    else            rd_q <= '0;
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/icc_ctrl.sv
module icc_ctrl import icc_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = addr_width(N_GRP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] ev_tx_i,
  input  logic [DATA_W-1:0] ev_rx_i,
  input  logic [DATA_W-1:0] ev_misc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);

  logic [N_GRP-1:0][DATA_W-1:0] ev_all, cause_w, mask_w, mode_w;
  logic [N_GRP-1:0] pend_w, rd_cause_w, wr_cause_w, wr_mset_w, wr_mclr_w, wr_mode_w;
  logic [N_GRP-1:0] sum_w, smask_w;
  logic             rd_sum_w, wr_smask_w;

  assign ev_all[GRP_TX]   = ev_tx_i;
  assign ev_all[GRP_RX]   = ev_rx_i;
  assign ev_all[GRP_MISC] = ev_misc_i;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    icc_group #(.W(DATA_W)) u_grp (
      .clk      (clk),
      .rst      (rst),
      .ev       (ev_all[g]),
      .rd_cause (rd_cause_w[g]),
      .wr_cause (wr_cause_w[g]),
      .wr_mset  (wr_mset_w[g]),
      .wr_mclr  (wr_mclr_w[g]),
      .wr_mode  (wr_mode_w[g]),
      .wdata    (wr_data_i),
      .cause_o  (cause_w[g]),
      .mask_o   (mask_w[g]),
      .mode_o   (mode_w[g]),
      .pend_o   (pend_w[g])
    );
  end

  icc_summary #(.G(N_GRP)) u_sum (
    .clk      (clk),
    .rst      (rst),
    .act      (pend_w),
    .rd_sum   (rd_sum_w),
    .wr_smask (wr_smask_w),
    .wdata    (wr_data_i[N_GRP-1:0]),
    .sum_o    (sum_w),
    .smask_o  (smask_w),
    .irq_o    (irq_o)
  );

  icc_regif #(.W(DATA_W), .G(N_GRP), .AW(ADDR_W)) u_regif (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr_i),
    .wr_en    (wr_en_i),
    .rd_en    (rd_en_i),
    .cause    (cause_w),
    .mask     (mask_w),
    .mode     (mode_w),
    .sum      (sum_w),
    .smask    (smask_w),
    .rd_cause (rd_cause_w),
    .wr_cause (wr_cause_w),
    .wr_mset  (wr_mset_w),
    .wr_mclr  (wr_mclr_w),
    .wr_mode  (wr_mode_w),
    .rd_sum   (rd_sum_w),
    .wr_smask (wr_smask_w),
    .rd_data  (rd_data_o)
  );

endmodule

// File: rtl/icc_chk.sv
module icc_chk import icc_pkg::*; #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input logic                    clk,
  input logic                    rst,
  input logic [N_GRP-1:0][W-1:0] ev,
  input logic [AW-1:0]           addr,
  input logic                    wr_en,
  input logic [W-1:0]            wr_data,
  input logic                    rd_en,
  input logic [N_GRP-1:0][W-1:0] cause,
  input logic [N_GRP-1:0][W-1:0] mask,
  input logic [N_GRP-1:0]        sum,
  input logic [N_GRP-1:0]        smask,
  input logic                    irq_o
);

  localparam logic [AW-1:0] A_SUM = AW'(N_GRP * GRP_SPAN);

  for (genvar g = 0; g < N_GRP; g++) begin : g_chk
    localparam logic [AW-1:0] A_CAUSE = AW'(g * GRP_SPAN);
    localparam logic [AW-1:0] A_MSET  = AW'(g * GRP_SPAN + 1);
    localparam logic [AW-1:0] A_MCLR  = AW'(g * GRP_SPAN + 2);

    // R1
    ev_latch_chk: assert property (@(posedge clk) disable iff (rst)
      (|ev[g]) |=> ((cause[g] & $past(ev[g])) == $past(ev[g])));

    // R2
    cause_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !((rd_en || wr_en) && addr == A_CAUSE) |=> ((~cause[g] & $past(cause[g])) == '0));

    // R3
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == A_MSET) |=>
        (((mask[g] & $past(wr_data)) == $past(wr_data)) &&
         (((mask[g] ^ $past(mask[g])) & ~$past(wr_data)) == '0)));

    // R4
    mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == A_MCLR) |=>
        (((mask[g] & $past(wr_data)) == '0) &&
         (((mask[g] ^ $past(mask[g])) & ~$past(wr_data)) == '0)));

    // R5
    mask_stable_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && (addr == A_MSET || addr == A_MCLR)) |=> $stable(mask[g]));
  end

  // R6
  sum_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && addr == A_SUM) |=> ((~sum & $past(sum)) == '0));

  // R7
  summary_off_chk: assert property (@(posedge clk) disable iff (rst)
    (&smask) |=> !irq_o);

  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == (|($past(sum) & ~$past(smask)))));

endmodule

bind icc_ctrl icc_chk #(.W(DATA_W), .AW(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ev      (ev_all),
  .addr    (addr_i),
  .wr_en   (wr_en_i),
  .wr_data (wr_data_i),
  .rd_en   (rd_en_i),
  .cause   (cause_w),
  .mask    (mask_w),
  .sum     (sum_w),
  .smask   (smask_w),
  .irq_o   (irq_o)
);

// File: tb/tb_icc_ctrl.sv
module tb_icc_ctrl;

  localparam logic [1:0] OP_WR = 2'd0;
  localparam logic [1:0] OP_RD = 2'd1;
  localparam logic [1:0] OP_EV = 2'd2;
  localparam logic [1:0] OP_IRQ = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  req;
    logic [4:0]  a;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam int NV = 47;
  localparam vec_t VEC [NV] = '{
    '{OP_RD, 4'd9, 5'h03, 32'h0, 32'hFFFF_FFFF},       // R9 tx mask
    '{OP_RD, 4'd9, 5'h04, 32'h0, 32'h0},               // R9 tx mode
    '{OP_RD, 4'd9, 5'h19, 32'h0, 32'h7},               // R9 summary mask
    '{OP_RD, 4'd9, 5'h18, 32'h0, 32'h0},               // R9 summary
    '{OP_EV, 4'd1, 5'h00, 32'h5, 32'h0},               // R1
    '{OP_RD, 4'd1, 5'h00, 32'h0, 32'h5},               // R1 latched while masked
    '{OP_RD, 4'd2, 5'h00, 32'h0, 32'h5},               // R2 read keeps W1C bits
    '{OP_IRQ, 4'd7, 5'h00, 32'h0, 32'h0},              // R7
    '{OP_WR, 4'd4, 5'h02, 32'h1, 32'h0},               // R4
    '{OP_RD, 4'd4, 5'h03, 32'h0, 32'hFFFF_FFFE},       // R4
    '{OP_WR, 4'd7, 5'h19, 32'h0, 32'h0},               // R7
    '{OP_IRQ, 4'd8, 5'h00, 32'h0, 32'h1},              // R8
    '{OP_RD, 4'd6, 5'h18, 32'h0, 32'h1},               // R6
    '{OP_IRQ, 4'd6, 5'h00, 32'h0, 32'h0},              // R6
    '{OP_RD, 4'd6, 5'h18, 32'h0, 32'h0},               // R6
    '{OP_WR, 4'd2, 5'h00, 32'h1, 32'h0},               // R2
    '{OP_RD, 4'd2, 5'h00, 32'h0, 32'h4},               // R2
    '{OP_WR, 4'd2, 5'h0C, 32'hF0, 32'h0},              // R2
    '{OP_RD, 4'd2, 5'h0C, 32'h0, 32'hF0},              // R2
    '{OP_EV, 4'd2, 5'h01, 32'h11, 32'h0},              // R2
    '{OP_RD, 4'd2, 5'h08, 32'h0, 32'h11},              // R2
    '{OP_RD, 4'd2, 5'h08, 32'h0, 32'h01},              // R2 COR bit gone
    '{OP_EV, 4'd2, 5'h01, 32'h10, 32'h0},              // R2
    '{OP_WR, 4'd2, 5'h08, 32'h10, 32'h0},              // R2 write ignored on COR bit
    '{OP_RD, 4'd2, 5'h08, 32'h0, 32'h11},              // R2
    '{OP_WR, 4'd2, 5'h08, 32'h01, 32'h0},              // R2
    '{OP_RD, 4'd2, 5'h08, 32'h0, 32'h0},               // R2
    '{OP_WR, 4'd3, 5'h01, 32'hFFFF_FFFF, 32'h0},       // R3
    '{OP_RD, 4'd3, 5'h03, 32'h0, 32'hFFFF_FFFF},       // R3
    '{OP_WR, 4'd5, 5'h03, 32'h0, 32'h0},               // R5
    '{OP_RD, 4'd5, 5'h03, 32'h0, 32'hFFFF_FFFF},       // R5
    '{OP_WR, 4'd4, 5'h0A, 32'h0000_FFFF, 32'h0},       // R4
    '{OP_WR, 4'd3, 5'h09, 32'h0000_00FF, 32'h0},       // R3
    '{OP_RD, 4'd3, 5'h0B, 32'h0, 32'hFFFF_00FF},       // R3
    '{OP_WR, 4'd4, 5'h12, 32'h2, 32'h0},               // R4
    '{OP_EV, 4'd6, 5'h02, 32'h2, 32'h0},               // R6
    '{OP_IRQ, 4'd8, 5'h00, 32'h0, 32'h1},              // R8
    '{OP_RD, 4'd6, 5'h18, 32'h0, 32'h4},               // R6
    '{OP_IRQ, 4'd8, 5'h00, 32'h0, 32'h0},              // R8
    '{OP_WR, 4'd2, 5'h10, 32'h2, 32'h0},               // R2
    '{OP_WR, 4'd7, 5'h19, 32'h7, 32'h0},               // R7
    '{OP_EV, 4'd7, 5'h02, 32'h2, 32'h0},               // R7
    '{OP_IRQ, 4'd7, 5'h00, 32'h0, 32'h0},              // R7
    '{OP_RD, 4'd7, 5'h18, 32'h0, 32'h4},               // R7 latched though blocked
    '{OP_EV, 4'd11, 5'h00, 32'h8100_0000, 32'h0},      // R11
    '{OP_RD, 4'd11, 5'h00, 32'h0, 32'h8100_0004},      // R11
    '{OP_RD, 4'd10, 5'h1F, 32'h0, 32'h0}               // R10 unmapped
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ev_tx = '0, ev_rx = '0, ev_misc = '0;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  icc_ctrl dut (
    .clk       (clk),
    .rst       (rst),
    .ev_tx_i   (ev_tx),
    .ev_rx_i   (ev_rx),
    .ev_misc_i (ev_misc),
    .addr_i    (addr),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_en_i   (rd_en),
    .rd_data_o (rd_data),
    .irq_o     (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic do_event(input logic [1:0] g, input logic [31:0] d);
    @(negedge clk);
    case (g)
      2'd0:    ev_tx = d;
      2'd1:    ev_rx = d;
      default: ev_misc = d;
    endcase
    @(negedge clk);
    ev_tx = '0; ev_rx = '0; ev_misc = '0;
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R9", {31'b0, irq}, 32'h0);
    check("R10", rd_data, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_WR: do_write(VEC[i].a, VEC[i].d);
        OP_RD: begin
          do_read(VEC[i].a, v);
          check($sformatf("R%0d vec %0d", VEC[i].req, i), v, VEC[i].e);
        end
        OP_EV: do_event(VEC[i].a[1:0], VEC[i].d);
        default: begin
          repeat (2) @(negedge clk);
          check($sformatf("R%0d vec %0d irq", VEC[i].req, i), {31'b0, irq}, VEC[i].e);
        end
      endcase
    end

    // R10 read data returns to zero the cycle after
    @(negedge clk);
    check("R10", rd_data, 32'h0);

    // R1 event beats same-cycle clear-on-read (rx bit 4 is clear-on-read)
    do_event(2'd1, 32'h10);
    @(negedge clk);
    addr = 5'h08; rd_en = 1'b1; ev_rx = 32'h10;
    @(negedge clk);
    rd_en = 1'b0; ev_rx = '0;
    check("R1", rd_data, 32'h10);
    do_read(5'h08, v);
    check("R1", v, 32'h10);
    do_read(5'h08, v);
    check("R2", v, 32'h0);

    // R1 event beats same-cycle write-one clear (rx bit 0 is write-one)
    do_event(2'd1, 32'h1);
    @(negedge clk);
    addr = 5'h08; wr_en = 1'b1; wr_data = 32'h1; ev_rx = 32'h1;
    @(negedge clk);
    wr_en = 1'b0; ev_rx = '0;
    do_read(5'h08, v);
    check("R1", v, 32'h1);
    do_write(5'h08, 32'h1);
    do_read(5'h08, v);
    check("R2", v, 32'h0);

    // R9 reset in the middle of a run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9", {31'b0, irq}, 32'h0);
    do_read(5'h00, v);
    check("R9", v, 32'h0);
    do_read(5'h0C, v);
    check("R9", v, 32'h0);
    do_read(5'h0B, v);
    check("R9", v, 32'hFFFF_FFFF);
    do_read(5'h19, v);
    check("R9", v, 32'h7);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule